// File: doc/BRIEF.md
# SPI Master Command-Driven Shift Engine

This block is the serial core of an SPI master. It reads a stream of 32-bit words from a transmit FIFO. Each word carries a tag bit that marks it as a command or as data. A command sets the frame length, clock polarity, clock phase and target chip select for the frames that follow. It also states whether chip select stays asserted once the FIFO runs dry, and whether the command joins an assertion that is already in progress. Data words are shifted out MSB first on MOSI. The bits sampled from MISO are pushed into a receive FIFO, one word per frame.

The half-period timing strobe `tick_i` comes from an external clock generator. Every SCK edge, the setup interval before the first edge and the release delay after the last frame are counted in these strobes. FIFO storage, the register bus and interrupt logic sit outside this block. The rest of the system uses the one-cycle `frame_done_o` pulse to learn that a chip-select assertion has ended.

Top module: `spi_cmd_engine`

## Requirements
- R1: A FIFO word with `tx_cmd_i`=1 is a command. Its fields are: [4:0] frame size minus one (values below 7 give 8 bits, so sizes run 8 to 32), [18] transmit mask, [19] receive mask, [20] continuing, [21] continuous, [25:24] chip-select lane, [30] CPHA, [31] CPOL. A plain command is consumed without starting a frame. A word is popped only while `tx_valid_i` is high.
- R2: A data frame of N bits sends `tx_data_i[N-1:0]` MSB first on MOSI. The N bits sampled from MISO (first bit most significant) appear right-aligned on `rx_data_o` with zeros above, and `rx_push_o` pulses once per frame.
- R3: SCK rests at CPOL whenever no chip select is active. With CPHA=0, MOSI holds the first bit before the first SCK edge, and MISO is sampled on leading edges. With CPHA=1, MOSI changes on leading edges and is sampled on trailing edges.
- R4: Only the lane named by the command is ever active, and at most one lane is active at a time. `cs_pol_i[l]`=1 makes lane l active high; 0 makes it active low.
- R5: When continuous is clear and another data word is already queued at the end of a frame, that word is sent within the same chip-select assertion.
- R6: When continuous is clear and the FIFO holds no data word, chip select is released `GAP_TICKS` strobes after the frame. `frame_done_o` is high for exactly the one cycle in which the release takes place.
- R7: When continuous is set, chip select stays asserted with the FIFO empty, and no `frame_done_o` pulse occurs.
- R8: A command with continuing set, arriving while a continuous assertion is held, keeps that assertion and its lane. A command without continuing first releases chip select (with a `frame_done_o` pulse) and then starts a fresh assertion.
- R9: With receive mask set, frames push nothing to the receive FIFO.
- R10: A command with transmit mask set starts one frame by itself, with MOSI low, and pops no data word.
- R11: Out of reset, every chip select is inactive, SCK is low, and `tx_pop_o`, `rx_push_o` and `frame_done_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Core clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | Half SCK period strobe from clock generator |
| cs_pol_i | input | 4 | Per-lane chip-select polarity, 1 = active high |
| tx_valid_i | input | 1 | Transmit FIFO holds a word |
| tx_cmd_i | input | 1 | Head word is a command |
| tx_data_i | input | 32 | Head word of transmit FIFO |
| tx_pop_o | output | 1 | Consume head word |
| rx_push_o | output | 1 | Write received word |
| rx_data_o | output | 32 | Received word, right-aligned |
| sck_o | output | 1 | Serial clock |
| mosi_o | output | 1 | Serial data out |
| miso_i | input | 1 | Serial data in |
| cs_o | output | 4 | Chip-select lanes |
| frame_done_o | output | 1 | One-cycle pulse at chip-select release |

## Verification
Errors in the edge counter or bit index show up at the end of the first frame. The captured MOSI word or the pushed MISO word is then shifted or truncated, so a bench acting as an SPI slave sees the error at once. If the sequencer mishandles the continuous or continuing flags, the bench sees a wrong number of chip-select assertions or `frame_done_o` pulses for that command group, or a lane change during a held assertion. A stuck mask or wrong tag decode alters the pop or push counts once the frame completes. The properties catch a pulse, pop or push at the wrong moment on the very cycle it happens.

// File: rtl/spi_cmd_pkg.sv
package spi_cmd_pkg;
  localparam int DW     = 32;
  localparam int NUM_CS = 4;
  localparam int LW     = $clog2(NUM_CS);
  localparam int NBW    = $clog2(DW) + 1;

  typedef struct packed {
    logic           cpol;
    logic           cpha;
    logic [LW-1:0]  lane;
    logic           cont;
    logic           contc;
    logic           rxmsk;
    logic           txmsk;
    logic [NBW-1:0] nbits;
  } cmd_t;

  function automatic cmd_t cmd_decode(logic [DW-1:0] w);
    cmd_t c;
    c.cpol  = w[31];
    c.cpha  = w[30];
    c.lane  = w[25:24];
    c.cont  = w[21];
    c.contc = w[20];
    c.rxmsk = w[19];
    c.txmsk = w[18];
    c.nbits = (w[4:0] < 5'd7) ? NBW'(8) : (NBW'(w[4:0]) + NBW'(1));
    return c;
  endfunction

  localparam cmd_t CMD_RST = '{cpol: 1'b0, cpha: 1'b0, lane: '0, cont: 1'b0,
                               contc: 1'b0, rxmsk: 1'b0, txmsk: 1'b0, nbits: NBW'(8)};
endpackage

// File: rtl/spi_cs_drive.sv
module spi_cs_drive
  import spi_cmd_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              act_i,
  input  logic [LW-1:0]     lane_i,
  input  logic [NUM_CS-1:0] pol_i,
  output logic [NUM_CS-1:0] cs_o
);
  for (genvar l = 0; l < NUM_CS; l++) begin : g_lane
    logic on_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) on_q <= 1'b0;
      else         on_q <= act_i && (lane_i == LW'(l));
    end
    // polarity applied after the flop, so reset is inactive for any setting
    assign cs_o[l] = ~(on_q ^ pol_i[l]);
  end
endmodule

// File: rtl/spi_shifter.sv
module spi_shifter
  import spi_cmd_pkg::*;
(
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           tick_i,
  input  logic           load_i,
  input  logic [DW-1:0]  data_i,
  input  logic           cpol_i,
  input  logic           cpha_i,
  input  logic [NBW-1:0] nbits_i,
  input  logic           idle_i,
  input  logic           run_i,
  input  logic           miso_i,
  output logic           sck_o,
  output logic           mosi_o,
  output logic           done_o,
  output logic [DW-1:0]  rx_o
);
  localparam int EW = NBW + 1;

  logic [DW-1:0]  txw_q, rxsh_q;
  logic [NBW-1:0] nb_q;
  logic [EW-1:0]  ecnt_q, elast;
  logic           cpha_q, sck_q, mosi_q, done_q;
  logic [NBW-1:0] bidx, bnxt;
  logic           lead, fin, step;

  assign elast = {nb_q, 1'b0};
  assign fin   = (ecnt_q == elast);
  assign step  = run_i && tick_i && !fin;
  assign lead  = ~ecnt_q[0];
  assign bidx  = nb_q - NBW'(1) - ecnt_q[EW-1:1];
  assign bnxt  = bidx - NBW'(1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      txw_q  <= '0;
      rxsh_q <= '0;
      nb_q   <= NBW'(8);
      ecnt_q <= '0;
      cpha_q <= 1'b0;
      sck_q  <= 1'b0;
      mosi_q <= 1'b0;
      done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (load_i) begin
        txw_q  <= data_i;
        rxsh_q <= '0;
        nb_q   <= nbits_i;
        ecnt_q <= '0;
        cpha_q <= cpha_i;
        sck_q  <= cpol_i;
        mosi_q <= cpha_i ? 1'b0 : data_i[nbits_i[4:0] - 5'd1];
      end else if (idle_i) begin
        sck_q <= cpol_i;
      end else if (step) begin
        sck_q  <= ~sck_q;
        ecnt_q <= ecnt_q + EW'(1);
        done_q <= (ecnt_q == elast - EW'(1));
        if (lead ^ cpha_q) rxsh_q <= {rxsh_q[DW-2:0], miso_i};
        else if (lead)     mosi_q <= txw_q[bidx[4:0]];
        else if (bidx != '0) mosi_q <= txw_q[bnxt[4:0]];
      end
    end
  end

  assign sck_o  = sck_q;
  assign mosi_o = mosi_q;
  assign done_o = done_q;
  assign rx_o   = rxsh_q;
endmodule

// File: rtl/spi_seq.sv
module spi_seq
  import spi_cmd_pkg::*;
#(
  parameter int GAP_TICKS = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          tick_i,
  input  logic          tx_valid_i,
  input  logic          tx_cmd_i,
  input  logic [DW-1:0] tx_data_i,
  input  logic          shift_done_i,
  output logic          tx_pop_o,
  output logic          rx_push_o,
  output logic          load_o,
  output logic [DW-1:0] ld_data_o,
  output cmd_t          cmd_o,
  output logic          idle_o,
  output logic          run_o,
  output logic          act_o,
  output logic [LW-1:0] lane_o,
  output logic          frame_done_o
);
  localparam int GW = $clog2(GAP_TICKS + 1);

  typedef enum logic [2:0] {S_IDLE, S_SETUP, S_SHIFT, S_AFTER, S_GAP} st_e;

  st_e           st_q, st_d;
  cmd_t          cmd_q, cmd_d, dec;
  logic          mpend_q, mpend_d;
  logic          act_q, act_d, fd_q, fd_d;
  logic [LW-1:0] lane_q, lane_d;
  logic [GW-1:0] gcnt_q, gcnt_d;
  logic          have_data, have_cmd;

  assign dec       = cmd_decode(tx_data_i);
  assign have_data = tx_valid_i && !tx_cmd_i;
  assign have_cmd  = tx_valid_i && tx_cmd_i;

  always_comb begin
    st_d      = st_q;
    cmd_d     = cmd_q;
    mpend_d   = mpend_q;
    act_d     = act_q;
    lane_d    = lane_q;
    gcnt_d    = gcnt_q;
    fd_d      = 1'b0;
    tx_pop_o  = 1'b0;
    load_o    = 1'b0;
    ld_data_o = '0;
    unique case (st_q)
      S_IDLE: begin
        if (mpend_q) begin
          mpend_d = 1'b0;
          load_o  = 1'b1;
          lane_d  = cmd_q.lane;
          act_d   = 1'b1;
          st_d    = S_SETUP;
        end else if (have_cmd) begin
          tx_pop_o = 1'b1;
          cmd_d    = dec;
          mpend_d  = dec.txmsk;
        end else if (have_data && !cmd_q.txmsk) begin
          tx_pop_o  = 1'b1;
          load_o    = 1'b1;
          ld_data_o = tx_data_i;
          lane_d    = cmd_q.lane;
          act_d     = 1'b1;
          st_d      = S_SETUP;
        end
      end
      S_SETUP: if (tick_i) st_d = S_SHIFT;
      S_SHIFT: if (shift_done_i) st_d = S_AFTER;
      S_AFTER: begin
        gcnt_d = '0;
        if (mpend_q) begin
          mpend_d = 1'b0;
          load_o  = 1'b1;
          st_d    = S_SETUP;
        end else if (have_data && !cmd_q.txmsk) begin
          tx_pop_o  = 1'b1;
          load_o    = 1'b1;
          ld_data_o = tx_data_i;
          st_d      = S_SETUP;
        end else if (have_cmd) begin
          if (cmd_q.cont && dec.contc) begin
            tx_pop_o = 1'b1;
            cmd_d    = dec;
            mpend_d  = dec.txmsk;
          end else begin
            st_d = S_GAP;
          end
        end else if (!cmd_q.cont) begin
          st_d = S_GAP;
        end
      end
      S_GAP: begin
        if (tick_i) begin
          if (gcnt_q == GW'(GAP_TICKS - 1)) begin
            act_d = 1'b0;
            fd_d  = 1'b1;
            st_d  = S_IDLE;
          end else begin
            gcnt_d = gcnt_q + GW'(1);
          end
        end
      end
      default: st_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= S_IDLE;
      cmd_q   <= CMD_RST;
      mpend_q <= 1'b0;
      act_q   <= 1'b0;
      lane_q  <= '0;
      gcnt_q  <= '0;
      fd_q    <= 1'b0;
    end else begin
      st_q    <= st_d;
      cmd_q   <= cmd_d;
      mpend_q <= mpend_d;
      act_q   <= act_d;
      lane_q  <= lane_d;
      gcnt_q  <= gcnt_d;
      fd_q    <= fd_d;
    end
  end

  assign rx_push_o    = shift_done_i && !cmd_q.rxmsk;
  assign cmd_o        = cmd_q;
  assign idle_o       = (st_q == S_IDLE);
  assign run_o        = (st_q == S_SHIFT);
  assign act_o        = act_d;
  assign lane_o       = lane_d;
  assign frame_done_o = fd_q;
endmodule

// File: rtl/spi_cmd_engine.sv
module spi_cmd_engine
  import spi_cmd_pkg::*;
#(
  parameter int GAP_TICKS = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic [NUM_CS-1:0] cs_pol_i,
  input  logic              tx_valid_i,
  input  logic              tx_cmd_i,
  input  logic [DW-1:0]     tx_data_i,
  output logic              tx_pop_o,
  output logic              rx_push_o,
  output logic [DW-1:0]     rx_data_o,
  output logic              sck_o,
  output logic              mosi_o,
  input  logic              miso_i,
  output logic [NUM_CS-1:0] cs_o,
  output logic              frame_done_o
);
  cmd_t          cmd;
  logic          load, idle, run, act, sdone;
  logic [DW-1:0] ld_data;
  logic [LW-1:0] lane;

  spi_seq #(.GAP_TICKS(GAP_TICKS)) u_seq (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .tick_i       (tick_i),
    .tx_valid_i   (tx_valid_i),
    .tx_cmd_i     (tx_cmd_i),
    .tx_data_i    (tx_data_i),
    .shift_done_i (sdone),
    .tx_pop_o     (tx_pop_o),
    .rx_push_o    (rx_push_o),
    .load_o       (load),
    .ld_data_o    (ld_data),
    .cmd_o        (cmd),
    .idle_o       (idle),
    .run_o        (run),
    .act_o        (act),
    .lane_o       (lane),
    .frame_done_o (frame_done_o)
  );

  spi_shifter u_shift (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .tick_i  (tick_i),
    .load_i  (load),
    .data_i  (ld_data),
    .cpol_i  (cmd.cpol),
    .cpha_i  (cmd.cpha),
    .nbits_i (cmd.nbits),
    .idle_i  (idle),
    .run_i   (run),
    .miso_i  (miso_i),
    .sck_o   (sck_o),
    .mosi_o  (mosi_o),
    .done_o  (sdone),
    .rx_o    (rx_data_o)
  );

  spi_cs_drive u_cs (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .act_i  (act),
    .lane_i (lane),
    .pol_i  (cs_pol_i),
    .cs_o   (cs_o)
  );
endmodule

// File: rtl/spi_cmd_engine_chk.sv
module spi_cmd_engine_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic [3:0] cs_o,
  input logic [3:0] cs_pol_i,
  input logic       sck_o,
  input logic       tx_valid_i,
  input logic       tx_pop_o,
  input logic       rx_push_o,
  input logic       frame_done_o
);
  logic [3:0] act_v;
  assign act_v = ~(cs_o ^ cs_pol_i);

  a_r4_one_lane: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(act_v));

  a_r6_done_at_release: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_done_o |-> (act_v == 4'b0) && ($past(act_v) != 4'b0));

  a_r1_no_pop_empty: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_pop_o |-> tx_valid_i);

  a_r2_push_in_frame: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_push_o |-> (act_v != 4'b0));

  a_r3_sck_quiet_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((act_v == 4'b0) && !$past(tx_pop_o)) |-> $stable(sck_o));
endmodule

bind spi_cmd_engine spi_cmd_engine_chk u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .cs_o         (cs_o),
  .cs_pol_i     (cs_pol_i),
  .sck_o        (sck_o),
  .tx_valid_i   (tx_valid_i),
  .tx_pop_o     (tx_pop_o),
  .rx_push_o    (rx_push_o),
  .frame_done_o (frame_done_o)
);

// File: tb/sim_spi_cmd_engine.sv
`timescale 1ns/1ps
module sim_spi_cmd_engine;
  logic        clk = 1'b0, rst_n = 1'b0, tick = 1'b0;
  logic [3:0]  cs_pol = 4'b0000;
  logic        miso = 1'b0;
  logic        tx_pop, rx_push, sck, mosi, fdone;
  logic [31:0] rx_data;
  logic [3:0]  cs;

  logic        f_cmd [0:63];
  logic [31:0] f_dat [0:63];
  int          wr = 0, rd = 0;
  logic        tx_valid, tx_cmd;
  logic [31:0] tx_data;
  assign tx_valid = (rd < wr);
  assign tx_cmd   = f_cmd[rd % 64];
  assign tx_data  = f_dat[rd % 64];

  int nchk = 0, nfail = 0;
  int tdiv = 2, tcnt = 0;

  // slave model state
  logic        slv_cpol = 0, slv_cpha = 0;
  int          slv_n = 8;
  logic [31:0] slv_miso = 32'h0;
  logic [31:0] mcap [0:63];
  logic [31:0] rcap [0:63];
  int          mcnt = 0, rcnt = 0, acnt = 0, dcnt = 0, pcnt = 0, last_lane = -1, bc = 0;
  logic [31:0] cap = 0;
  logic        prev_act = 0, prev_sck = 0;
  logic [3:0]  act_v;

  always #10 clk = ~clk;

  spi_cmd_engine u0 (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .cs_pol_i(cs_pol),
    .tx_valid_i(tx_valid), .tx_cmd_i(tx_cmd), .tx_data_i(tx_data),
    .tx_pop_o(tx_pop), .rx_push_o(rx_push), .rx_data_o(rx_data),
    .sck_o(sck), .mosi_o(mosi), .miso_i(miso), .cs_o(cs), .frame_done_o(fdone)
  );

  always @(posedge clk) begin
    if (tx_pop) rd <= rd + 1;
    if (tcnt >= tdiv - 1) begin tcnt <= 0; tick <= 1'b1; end
    else begin tcnt <= tcnt + 1; tick <= 1'b0; end
  end

  always @(negedge clk) begin
    act_v = ~(cs ^ cs_pol);
    if (rst_n) begin
      if ((|act_v) && !prev_act) begin
        acnt++;
        for (int l = 0; l < 4; l++) if (act_v[l]) last_lane = l;
        bc = 0; cap = 0;
        if (!slv_cpha) miso = slv_miso[slv_n-1];
      end else if ((|act_v) && prev_act && (sck != prev_sck)) begin
        if ((prev_sck == slv_cpol) ^ slv_cpha) begin
          cap = {cap[30:0], mosi};
          bc++;
          if (bc == slv_n) begin mcap[mcnt % 64] = cap; mcnt++; bc = 0; cap = 0; end
        end else begin
          miso = slv_miso[slv_n-1-bc];
        end
      end
      if (rx_push) begin rcap[rcnt % 64] = rx_data; rcnt++; end
      if (fdone) dcnt++;
      if (tx_pop) pcnt++;
    end
    prev_act = |act_v;
    prev_sck = sck;
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic push(input logic c, input logic [31:0] d);
    @(negedge clk);
    f_cmd[wr % 64] = c;
    f_dat[wr % 64] = d;
    wr++;
  endtask

  function automatic logic [31:0] mk(input logic cpol, input logic cpha, input int lane,
                                     input logic cont, input logic contc, input logic rxm,
                                     input logic txm, input int szm1);
    logic [31:0] w = 32'h0;
    w[31] = cpol; w[30] = cpha; w[25:24] = 2'(lane);
    w[21] = cont; w[20] = contc; w[19] = rxm; w[18] = txm; w[4:0] = 5'(szm1);
    return w;
  endfunction

  task automatic slave(input logic cpol, input logic cpha, input int n, input logic [31:0] m);
    @(negedge clk);
    slv_cpol = cpol; slv_cpha = cpha; slv_n = n; slv_miso = m;
  endtask

  task automatic wait_done(input int target);
    for (int i = 0; i < 40000 && dcnt < target; i++) @(negedge clk);
    repeat (5) @(negedge clk);
  endtask

  task automatic t_reset;
    @(negedge clk);
    check("R11 cs idle", {28'h0, cs}, 32'hF);
    check("R11 sck low", {31'h0, sck}, 32'h0);
    check("R11 outputs low", {29'h0, tx_pop, rx_push, fdone}, 32'h0);
  endtask

  task automatic t_basic;
    int m0 = mcnt, r0 = rcnt, a0 = acnt, d0 = dcnt;
    slave(0, 0, 8, 32'h3C);
    push(1, mk(0, 0, 0, 0, 0, 0, 0, 7));
    push(0, 32'hFFFF_FFA5);
    wait_done(d0 + 1);
    check("R2 mosi 8b", mcap[m0 % 64], 32'hA5);
    check("R2 rx 8b", rcap[r0 % 64], 32'h3C);
    check("R4 lane0", last_lane, 0);
    check("R6 one release", dcnt - d0, 1);
    check("R6 one assertion", acnt - a0, 1);
  endtask

  task automatic t_mode3_32;
    int m0 = mcnt, r0 = rcnt, d0 = dcnt;
    slave(1, 1, 32, 32'h1234_5678);
    push(1, mk(1, 1, 2, 0, 0, 0, 0, 31));
    push(0, 32'hDEAD_BEEF);
    wait_done(d0 + 1);
    check("R3 mosi cpha1 32b", mcap[m0 % 64], 32'hDEAD_BEEF);
    check("R3 rx cpha1 32b", rcap[r0 % 64], 32'h1234_5678);
    check("R4 lane2", last_lane, 2);
    check("R3 sck idle high", {31'h0, sck}, 32'h1);
  endtask

  task automatic t_back2back;
    int m0 = mcnt, r0 = rcnt, a0 = acnt, d0 = dcnt;
    slave(0, 1, 12, 32'h0000_0A5C);
    push(1, mk(0, 1, 1, 0, 0, 0, 0, 11));
    push(0, 32'h0000_0123);
    push(0, 32'h0000_0FED);
    wait_done(d0 + 1);
    check("R5 first word", mcap[m0 % 64], 32'h123);
    check("R5 second word", mcap[(m0 + 1) % 64], 32'hFED);
    check("R5 rx second", rcap[(r0 + 1) % 64], 32'hA5C);
    check("R5 single assertion", acnt - a0, 1);
    check("R3 sck idle low", {31'h0, sck}, 32'h0);
  endtask

  task automatic t_cont;
    int m0 = mcnt, a0 = acnt, d0 = dcnt;
    slave(0, 0, 16, 32'h0000_C3A5);
    push(1, mk(0, 0, 3, 1, 0, 0, 0, 15));
    push(0, 32'h0000_BEEF);
    for (int i = 0; i < 20000 && mcnt == m0; i++) @(negedge clk);
    repeat (100) @(negedge clk);
    check("R7 cs held", {28'h0, cs}, 32'h7);
    check("R7 no pulse", dcnt - d0, 0);
    push(1, mk(0, 0, 0, 0, 1, 0, 0, 15));
    push(0, 32'h0000_1234);
    wait_done(d0 + 1);
    check("R8 continued word", mcap[(m0 + 1) % 64], 32'h1234);
    check("R8 lane kept", last_lane, 3);
    check("R8 single assertion", acnt - a0, 1);
  endtask

  task automatic t_fresh;
    int a0 = acnt, d0 = dcnt, m0 = mcnt;
    slave(0, 0, 8, 32'h5A);
    push(1, mk(0, 0, 1, 1, 0, 0, 0, 7));
    push(0, 32'h11);
    for (int i = 0; i < 20000 && mcnt == m0; i++) @(negedge clk);
    push(1, mk(0, 0, 2, 0, 0, 0, 0, 7));
    push(0, 32'h22);
    wait_done(d0 + 2);
    check("R8 two releases", dcnt - d0, 2);
    check("R8 two assertions", acnt - a0, 2);
    check("R8 new lane", last_lane, 2);
  endtask

  task automatic t_rxmask;
    int m0 = mcnt, r0 = rcnt, d0 = dcnt;
    slave(0, 0, 8, 32'hFF);
    push(1, mk(0, 0, 0, 0, 0, 1, 0, 3));
    push(0, 32'h0000_0196);
    wait_done(d0 + 1);
    check("R9 no push", rcnt - r0, 0);
    check("R1 small size gives 8b", mcap[m0 % 64], 32'h96);
  endtask

  task automatic t_txmask;
    int m0 = mcnt, r0 = rcnt, d0 = dcnt, p0 = pcnt;
    slave(0, 0, 8, 32'h81);
    push(1, mk(0, 0, 1, 0, 0, 0, 1, 7));
    wait_done(d0 + 1);
    check("R10 mosi low", mcap[m0 % 64], 32'h0);
    check("R10 rx word", rcap[r0 % 64], 32'h81);
    check("R10 one pop", pcnt - p0, 1);
    check("R10 one frame", mcnt - m0, 1);
  endtask

  task automatic t_polarity;
    int m0 = mcnt, d0 = dcnt;
    slave(0, 0, 8, 32'h0);
    cs_pol = 4'b0001;
    repeat (2) @(negedge clk);
    check("R4 idle with active-high lane0", {28'h0, cs}, 32'hE);
    push(1, mk(0, 0, 0, 0, 0, 0, 0, 7));
    push(0, 32'h6B);
    for (int i = 0; i < 20000 && !(cs == 4'b1111); i++) @(negedge clk);
    check("R4 lane0 driven high", {28'h0, cs}, 32'hF);
    wait_done(d0 + 1);
    check("R4 word on high lane", mcap[m0 % 64], 32'h6B);
    check("R4 released", {28'h0, cs}, 32'hE);
    cs_pol = 4'b0000;
    repeat (2) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    t_basic();
    t_mode3_32();
    tdiv = 3;
    t_back2back();
    t_cont();
    tdiv = 1;
    t_fresh();
    tdiv = 2;
    t_rxmask();
    t_txmask();
    t_polarity();
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    nchk++;
    nfail++;
    $display("FAIL watchdog actual hung expected finished");
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end
endmodule